// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel. It keeps a 32-bit timing word for each of the two devices on the channel. A configuration port writes these words through a class-dependent masked merge.

A host request names the target device, the direction, whether the access is a data cycle or a task-file register cycle, and a word count. The block takes the setup count and the active and inactive strobe counts for that access class from the selected device's word. It then plays out an optional setup period, followed by one active phase and one inactive phase per word. Read data is captured from the device bus at the end of each active phase. Write data is driven onto the bus during each active phase. A one-clock done pulse closes the burst.

The Ultra DMA, multiword DMA, bus-master and FIFO enable fields are kept in the timing words. The Ultra DMA cycle field is kept as well. None of them change strobe timing.

Top module: `ata_strobe_timer`

## Requirements
- R1: After reset both strobes are high, dd_oe, busy and done are low, and both timing words read back as zero.
- R2: Device 0's word sits at byte address BASE (default 0x40) and device 1's word at BASE+4. cfg_rdata shows the word at cfg_addr in the same cycle, and shows zero for any other address. A write to any other address changes neither word.
- R3: A configuration write with cfg_mode 0 (PIO) merges through mask 0xC1F8FFFF, mode 1 (multiword DMA) through 0x303800FF and mode 2 (Ultra DMA) through 0x30070000. The stored word is (old & ~mask) | (new & mask) with bits 31:30 then cleared. Mode 3 leaves the word unchanged.
- R4: For data-class requests (req_taskfile=0), each active strobe phase lasts bits 7:4 + 1 clocks and each inactive phase lasts bits 3:0 + 1 clocks.
- R5: For task-file requests (req_taskfile=1), the active phase lasts bits 15:12 + 1 clocks and the inactive phase lasts bits 11:8 + 1 clocks.
- R6: A setup period precedes only the first word of a burst. It lasts bits 21:19 clocks for data requests and bits 24:22 clocks for task-file requests, and a value of zero inserts none.
- R7: The first clock after acceptance is the first setup clock, or the first active clock when there is no setup. A read (req_write=0) pulses only dior_n and a write pulses only diow_n; both strobes are never low together.
- R8: On the last clock of every read active phase, rd_bus is captured into rd_data and rd_valid pulses on the following clock.
- R9: At the clock edge that begins each write active phase, wr_data is latched. dd_out holds that value, with dd_oe high, for the whole active phase, and dd_oe is low at all other times.
- R10: done is high for exactly the one clock after the final inactive phase. busy is high from the clock after acceptance through the done clock.
- R11: A request with req_len = 0 raises done in the first clock after acceptance and never lowers a strobe.
- R12: A request presented while busy is high is ignored.
- R13: Bits 31:28 and 18:16 of a timing word are stored and read back but do not change strobe timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | ADDR_W (8) | Configuration byte address |
| cfg_mode | input | 2 | Merge class: 0 PIO, 1 multiword DMA, 2 Ultra DMA, 3 hold |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Timing word at cfg_addr |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_dev | input | 1 | Target device |
| req_write | input | 1 | 1 = write, 0 = read |
| req_taskfile | input | 1 | 1 = task-file register access, 0 = data |
| req_len | input | LEN_W (8) | Words in the burst |
| wr_data | input | DATA_W (16) | Write data, latched at each write active-phase start |
| rd_bus | input | DATA_W (16) | Data bus from the device |
| dd_out | output | DATA_W (16) | Data driven to the device |
| dd_oe | output | 1 | Bus drive enable |
| dior_n | output | 1 | Active-low read strobe |
| diow_n | output | 1 | Active-low write strobe |
| rd_data | output | DATA_W (16) | Last captured read word |
| rd_valid | output | 1 | One-clock pulse after each capture |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock burst completion pulse |

## Verification
Cycles are numbered from the edge that takes the request, which is cycle 0. With setup S, active count A, inactive count I and N words, word w's active phase runs from cycle S+1+w(A+I+2) for A+1 cycles, and done is due in cycle S+N(A+I+2)+1. The captured read value is the bus value present at the last active clock of the final word, so the bench drives a cycle-indexed pattern on rd_bus and wr_data and predicts both values from the cycle number alone. Every output is compared at the falling edge of every cycle of each burst and of three idle cycles after it. Readback of a configuration write is checked one cycle after the write edge.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;

  localparam int WORD_W = 32;

  // Merge class carried by a configuration write.
  typedef enum logic [1:0] {
    CFG_PIO   = 2'd0,
    CFG_MWDMA = 2'd1,
    CFG_UDMA  = 2'd2,
    CFG_HOLD  = 2'd3
  } cfg_class_e;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_ACT   = 3'd2,
    PH_INACT = 3'd3,
    PH_DONE  = 3'd4
  } phase_e;

  // Counts selected for one request.
  typedef struct packed {
    logic [2:0] setup;
    logic [3:0] act;
    logic [3:0] inact;
  } phase_cnt_t;

  // Bits 31:30 never survive a write.
  localparam logic [WORD_W-1:0] TOP_CLEAR = 32'h3FFF_FFFF;

  function automatic logic [WORD_W-1:0] class_mask(input cfg_class_e c);
    case (c)
      CFG_PIO:   class_mask = 32'hC1F8_FFFF;
      CFG_MWDMA: class_mask = 32'h3038_00FF;
      CFG_UDMA:  class_mask = 32'h3007_0000;
      default:   class_mask = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/ata_timing_regs.sv
module ata_timing_regs
  import ata_strobe_pkg::*;
#(
  parameter int              ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE = 8'h40,
  parameter int              NDEV   = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_we,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [1:0]               cfg_mode,
  input  logic [WORD_W-1:0]        cfg_wdata,
  output logic [WORD_W-1:0]        cfg_rdata,
  output logic [NDEV*WORD_W-1:0]   words
);

  localparam int DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam int HI_LO = 2 + DEV_W;

  logic [DEV_W-1:0]   dev_idx;
  logic               addr_hit;
  logic [WORD_W-1:0]  mask;

  assign dev_idx  = cfg_addr[2 +: DEV_W];
  assign addr_hit = (cfg_addr[1:0] == 2'b00) &&
                    (cfg_addr[ADDR_W-1:HI_LO] == BASE[ADDR_W-1:HI_LO]) &&
                    (int'(dev_idx) < NDEV);
  assign mask     = class_mask(cfg_class_e'(cfg_mode));

  for (genvar g = 0; g < NDEV; g++) begin : g_word
    logic [WORD_W-1:0] word_q, word_d;
    logic              word_en;

    assign word_en = cfg_we && addr_hit && (dev_idx == DEV_W'(g));

    always_comb begin
      word_d = ((word_q & ~mask) | (cfg_wdata & mask)) & TOP_CLEAR;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (word_en) begin
        word_q <= word_d;
      end
    end

    assign words[g*WORD_W +: WORD_W] = word_q;
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NDEV; k++) begin
      if (addr_hit && (dev_idx == DEV_W'(k))) begin
        cfg_rdata = words[k*WORD_W +: WORD_W];
      end
    end
  end

endmodule

// File: rtl/ata_phase_pick.sv
module ata_phase_pick
  import ata_strobe_pkg::*;
(
  input  logic [15:0] strobe_bits,
  input  logic [5:0]  setup_bits,
  input  logic        taskfile,
  output phase_cnt_t  cnt
);

  // setup_bits holds word bits 24:19; strobe_bits holds word bits 15:0.
  always_comb begin
    if (taskfile) begin
      cnt.setup = setup_bits[5:3];
      cnt.act   = strobe_bits[15:12];
      cnt.inact = strobe_bits[11:8];
    end else begin
      cnt.setup = setup_bits[2:0];
      cnt.act   = strobe_bits[7:4];
      cnt.inact = strobe_bits[3:0];
    end
  end

endmodule

// File: rtl/ata_phase_seq.sv
module ata_phase_seq
  import ata_strobe_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LEN_W-1:0]  req_len,
  input  phase_cnt_t        cnt_in,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_bus,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done
);

  localparam int CNT_W = 4;

  phase_e             st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [LEN_W-1:0]   left_q, left_d;
  logic [3:0]         act_q, act_d, ina_q, ina_d;
  logic               wr_q, wr_d;

  logic               ent_act, load_wd, capture;
  logic               rd_n_d, wr_n_d, oe_d;

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    left_d = left_q;
    act_d  = act_q;
    ina_d  = ina_q;
    wr_d   = wr_q;
    case (st_q)
      PH_IDLE: begin
        if (req_valid) begin
          wr_d   = req_write;
          act_d  = cnt_in.act;
          ina_d  = cnt_in.inact;
          left_d = req_len;
          if (req_len == '0) begin
            st_d = PH_DONE;
          end else if (cnt_in.setup != 3'd0) begin
            st_d  = PH_SETUP;
            cnt_d = {1'b0, cnt_in.setup} - 4'd1;
          end else begin
            st_d  = PH_ACT;
            cnt_d = cnt_in.act;
          end
        end
      end
      PH_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = PH_ACT;
          cnt_d = act_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_ACT: begin
        if (cnt_q == '0) begin
          st_d  = PH_INACT;
          cnt_d = ina_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_INACT: begin
        if (cnt_q == '0) begin
          if (left_q == LEN_W'(1)) begin
            st_d = PH_DONE;
          end else begin
            st_d   = PH_ACT;
            cnt_d  = act_q;
            left_d = left_q - 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_DONE: st_d = PH_IDLE;
      default: st_d = PH_IDLE;
    endcase
  end

  // Output next values, registered so the strobes never glitch.
  always_comb begin
    ent_act = (st_d == PH_ACT);
    load_wd = ent_act && (st_q != PH_ACT) && wr_d;
    capture = (st_q == PH_ACT) && (cnt_q == '0) && !wr_q;
    rd_n_d  = !(ent_act && !wr_d);
    wr_n_d  = !(ent_act && wr_d);
    oe_d    = ent_act && wr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      left_q <= '0;
      act_q  <= '0;
      ina_q  <= '0;
      wr_q   <= 1'b0;
      dior_n <= 1'b1;
      diow_n <= 1'b1;
      dd_oe  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      left_q <= left_d;
      act_q  <= act_d;
      ina_q  <= ina_d;
      wr_q   <= wr_d;
      dior_n <= rd_n_d;
      diow_n <= wr_n_d;
      dd_oe  <= oe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dd_out <= '0;
    end else if (load_wd) begin
      dd_out <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (capture) begin
      rd_data <= rd_bus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= capture;
    end
  end

  assign busy = (st_q != PH_IDLE);
  assign done = (st_q == PH_DONE);

endmodule

// File: rtl/ata_strobe_timer.sv
module ata_strobe_timer
  import ata_strobe_pkg::*;
#(
  parameter int                ADDR_W = 8,
  parameter logic [ADDR_W-1:0] BASE   = 8'h40,
  parameter int                LEN_W  = 8,
  parameter int                DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [1:0]        cfg_mode,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              req_valid,
  input  logic              req_dev,
  input  logic              req_write,
  input  logic              req_taskfile,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_bus,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              busy,
  output logic              done
);

  localparam int NDEV = 2;

  logic [NDEV*WORD_W-1:0] words;
  logic [WORD_W-1:0]      sel_word;
  phase_cnt_t             cnt_sel;

  ata_timing_regs #(
    .ADDR_W (ADDR_W),
    .BASE   (BASE),
    .NDEV   (NDEV)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_mode  (cfg_mode),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .words     (words)
  );

  assign sel_word = words[req_dev*WORD_W +: WORD_W];

  ata_phase_pick u_pick (
    .strobe_bits (sel_word[15:0]),
    .setup_bits  (sel_word[24:19]),
    .taskfile    (req_taskfile),
    .cnt         (cnt_sel)
  );

  ata_phase_seq #(
    .LEN_W  (LEN_W),
    .DATA_W (DATA_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_len   (req_len),
    .cnt_in    (cnt_sel),
    .wr_data   (wr_data),
    .rd_bus    (rd_bus),
    .dd_out    (dd_out),
    .dd_oe     (dd_oe),
    .dior_n    (dior_n),
    .diow_n    (diow_n),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .busy      (busy),
    .done      (done)
  );

endmodule

// File: rtl/ata_strobe_checker.sv
module ata_strobe_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [31:0]       cfg_rdata,
  input logic              dior_n,
  input logic              diow_n,
  input logic              dd_oe,
  input logic [DATA_W-1:0] dd_out,
  input logic              busy,
  input logic              done
);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!dior_n && !diow_n)); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (dior_n && diow_n && !done && !dd_oe)); // R10

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10

  AST_WDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!diow_n && $past(!diow_n)) |-> $stable(dd_out)); // R9

  AST_OE_WITH_WSTROBE: assert property (@(posedge clk) disable iff (!rst_n)
    dd_oe |-> !diow_n); // R9

  AST_TOP_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:30] == 2'b00); // R3

endmodule

bind ata_strobe_timer ata_strobe_checker #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_rdata (cfg_rdata),
  .dior_n    (dior_n),
  .diow_n    (diow_n),
  .dd_oe     (dd_oe),
  .dd_out    (dd_out),
  .busy      (busy),
  .done      (done)
);

// File: tb/ata_strobe_timer_bench.sv
`timescale 1ns/1ps
module ata_strobe_timer_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [7:0]  cfg_addr;
  logic [1:0]  cfg_mode;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        req_valid, req_dev, req_write, req_taskfile;
  logic [7:0]  req_len;
  logic [15:0] wr_data, rd_bus, dd_out, rd_data;
  logic        dd_oe, dior_n, diow_n, rd_valid, busy, done;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  logic [31:0] bw [2];

  always #2.5 clk = ~clk;

  ata_strobe_timer u_ata_strobe_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_mode(cfg_mode), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_dev(req_dev), .req_write(req_write),
    .req_taskfile(req_taskfile), .req_len(req_len), .wr_data(wr_data),
    .rd_bus(rd_bus), .dd_out(dd_out), .dd_oe(dd_oe), .dior_n(dior_n),
    .diow_n(diow_n), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [7:0] a, input logic [1:0] m, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_mode = m; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    #0.5;
    chk(cfg_rdata === exp, tag, cfg_rdata, exp);
  endtask

  // Runs one burst and compares every output in every cycle.
  task automatic run_txn(input bit dev, input bit wr, input bit tf, input bit inj,
                         input int len, input string tag);
    int s, a, i, p, tot, c, st, mism_s, mism_d, mism_w;
    logic [15:0] rd_at_done;
    logic b1, b_after;
    bit exp_act;
    s = tf ? int'(bw[dev][24:22]) : int'(bw[dev][21:19]);
    a = tf ? int'(bw[dev][15:12]) : int'(bw[dev][7:4]);
    i = tf ? int'(bw[dev][11:8])  : int'(bw[dev][3:0]);
    p = a + i + 2;
    tot = (len == 0) ? 1 : s + len * p + 1;
    c = s + (len - 1) * p + a + 1;
    mism_s = 0; mism_d = 0; mism_w = 0;
    rd_at_done = '0; b1 = 1'b0; b_after = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_dev = dev; req_write = wr; req_taskfile = tf;
    req_len = 8'(len); rd_bus = 16'h1000; wr_data = 16'h2000;
    for (int j = 1; j <= tot + 3; j++) begin
      @(negedge clk);
      exp_act = 1'b0; st = 0;
      if (len > 0 && j >= s + 1 && j < s + 1 + len * p) begin
        exp_act = ((j - s - 1) % p) <= a;
        st = s + 1 + ((j - s - 1) / p) * p;
      end
      if (dior_n !== !(exp_act && !wr) || diow_n !== !(exp_act && wr)) mism_s++;
      if (done !== (j == tot)) mism_d++;
      if (dd_oe !== (exp_act && wr)) mism_w++;
      if (exp_act && wr && dd_out !== 16'(16'h2000 + st - 1)) mism_w++;
      if (j == tot) rd_at_done = rd_data;
      if (j == 1) b1 = busy;
      if (j == tot + 1) b_after = busy;
      // drive after sampling
      rd_bus = 16'(16'h1000 + j);
      wr_data = 16'(16'h2000 + j);
      if (j == 1) req_valid = 1'b0;
      if (inj && j == 2) begin
        req_valid = 1'b1; req_dev = !dev; req_write = !wr; req_len = 8'd5;
      end
      if (j == 3) req_valid = 1'b0;
    end
    chk(mism_s == 0, {tag, " strobe timing"}, 32'(mism_s), 0);
    chk(mism_d == 0, "R10 done timing", 32'(mism_d), 0);
    chk(mism_w == 0, "R9 write data and enable", 32'(mism_w), 0);
    chk(b1 == (len > 0 || tot == 1) && b_after == 1'b0, "R10 busy window",
        {30'd0, b1, b_after}, {30'd0, 1'b1, 1'b0});
    if (!wr && len > 0)
      chk(rd_at_done === 16'(16'h1000 + c), "R8 read capture", 32'(rd_at_done), 32'(16'h1000 + c));
  endtask

  // {dev, write, taskfile, inject_busy_request, len[7:0]}
  localparam logic [11:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b0, 8'd1},
    {1'b0, 1'b1, 1'b0, 1'b1, 8'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 8'd2},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'd2},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'd1},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'd4},
    {1'b0, 1'b1, 1'b0, 1'b0, 8'd0},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'd3}
  };

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 8'h40; cfg_mode = 2'd0; cfg_wdata = '0;
    req_valid = 1'b0; req_dev = 1'b0; req_write = 1'b0; req_taskfile = 1'b0;
    req_len = '0; wr_data = '0; rd_bus = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(dior_n && diow_n && !dd_oe && !busy && !done, "R1 reset outputs",
        {27'd0, dior_n, diow_n, dd_oe, busy, done}, 32'h18);
    cfg_check(8'h40, 32'h0, "R1 dev0 word after reset");
    cfg_check(8'h44, 32'h0, "R1 dev1 word after reset");
    rst_n = 1'b1;

    // R3: PIO merge clears bits 31:30
    cfg_write(8'h40, 2'd0, 32'hF010_4132);
    cfg_check(8'h40, 32'h0010_4132, "R3 PIO merge dev0");
    // R3: UDMA merge keeps only its fields
    cfg_write(8'h44, 2'd2, 32'hFFFF_FFFF);
    cfg_check(8'h44, 32'h3007_0000, "R3 UDMA merge dev1");
    cfg_write(8'h44, 2'd0, 32'h00C0_0210);
    cfg_check(8'h44, 32'h30C7_0210, "R3 R13 PIO merge dev1");
    // R2: unmapped address ignored, reads as zero
    cfg_write(8'h48, 2'd0, 32'hFFFF_FFFF);
    cfg_check(8'h40, 32'h0010_4132, "R2 stray write dev0");
    cfg_check(8'h44, 32'h30C7_0210, "R2 stray write dev1");
    cfg_check(8'h48, 32'h0, "R2 stray read");
    // R3: hold class leaves word unchanged
    cfg_write(8'h40, 2'd3, 32'hFFFF_FFFF);
    cfg_check(8'h40, 32'h0010_4132, "R3 hold class");
    bw[0] = 32'h0010_4132;
    bw[1] = 32'h30C7_0210;

    for (int v = 0; v < 8; v++) begin
      if (VEC[v][7:0] == 8'd0)
        run_txn(VEC[v][11], VEC[v][10], VEC[v][9], VEC[v][8], 0, "R11 zero length");
      else if (VEC[v][8])
        run_txn(VEC[v][11], VEC[v][10], VEC[v][9], 1'b1, int'(VEC[v][7:0]), "R12 busy request ignored");
      else if (VEC[v][11])
        run_txn(VEC[v][11], VEC[v][10], VEC[v][9], 1'b0, int'(VEC[v][7:0]), "R13 R7 dev1 timing");
      else if (VEC[v][9])
        run_txn(VEC[v][11], VEC[v][10], VEC[v][9], 1'b0, int'(VEC[v][7:0]), "R5 R6 R7 taskfile");
      else
        run_txn(VEC[v][11], VEC[v][10], VEC[v][9], 1'b0, int'(VEC[v][7:0]), "R4 R6 R7 data");
    end

    // R3: multiword DMA merge, then a burst on the new counts
    cfg_write(8'h40, 2'd1, 32'h0000_0055);
    cfg_check(8'h40, 32'h0000_4155, "R3 MWDMA merge dev0");
    bw[0] = 32'h0000_4155;
    run_txn(1'b0, 1'b0, 1'b0, 1'b0, 2, "R4 R6 data after MWDMA");

    // R1: reset in mid-burst
    @(negedge clk);
    req_valid = 1'b1; req_dev = 1'b1; req_write = 1'b1; req_taskfile = 1'b0; req_len = 8'd4;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk(dior_n && diow_n && !dd_oe && !busy && !done, "R1 reset during burst",
        {27'd0, dior_n, diow_n, dd_oe, busy, done}, 32'h18);
    cfg_check(8'h44, 32'h0, "R1 word cleared by reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule